// File: doc/BRIEF.md
# SPI Byte Engine, Phase-Zero Clocking

This block moves one byte at a time over a four-wire serial link. It can run as bus master or as a selected slave. Data is always captured on the first clock edge of a bit time and the shifter advances on the second edge. The idle level of the serial clock and the order of the bits within the byte are both selectable.

As master, the block makes the serial clock and its select output from the system clock, using a programmable half-bit divider. A byte written to the write port starts a transfer as soon as the engine is idle. As slave, the clock and select inputs are resynchronised to the system clock. Their edges drive the sample and shift steps. The outgoing byte is reloaded from the write register on every falling edge of select.

In both modes, the received byte lands in a read register and a sticky completion flag is raised. When the enable input is low, every serial pin output enable is released.

Top module: `spi_cpha0_engine`

## Requirements
- R1: While `en` is low, all four pin output enables (`sck_oe`, `ss_oe`, `mosi_oe`, `miso_oe`) are low within one clock, and out of reset `rd_done` is 0 and `ss_o` is 1.
- R2: In master mode `ss_o` stays low from the start of a byte to its end, and the first clock edge comes exactly H system clocks after `ss_o` falls. H is `half_bit`, except that a value of 0 counts as 1, which gives a minimum divide ratio of 2.
- R3: In master mode the byte written to `wr_data` appears on `mosi_o` one bit per bit time over eight leading edges. The byte sampled from `miso_i` on those leading edges is returned on `rd_data`.
- R4: With `lsb_first`=1 bit 0 of the byte is transferred first. With `lsb_first`=0 bit 7 is transferred first. This applies in both modes and in both directions.
- R5: While idle, the serial clock rests at the level of `cpol`. The leading edge is the transition away from `cpol` and the trailing edge is the return to it.
- R6: Between two back-to-back master bytes, `ss_o` stays high for at least H system clocks.
- R7: In slave mode, within four system clocks of `ss_i` falling and before any clock edge, `miso_oe` is 1 and `miso_o` carries the first bit of the outgoing byte.
- R8: In slave mode the block samples `mosi_i` on each leading edge of `sck_i` and shifts on each trailing edge. After the eighth sample, `rd_data` holds the received byte and the outgoing byte has appeared on `miso_o`.
- R9: If `ss_i` rises before the eighth sample in slave mode, the partial byte is discarded, `rd_done` is not raised, and the next select starts counting again from bit one.
- R10: `rd_done` rises in the cycle after the eighth sample and stays high until a cycle with `rd_ack` high.
- R11: `sck_oe`, `ss_oe` and `mosi_oe` are high only in master mode. `miso_oe` is high only in slave mode while selected.
- R12: Without a new write, a slave sends the last written byte again on the next select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; when low, all pins are released |
| master | input | 1 | 1 selects master mode, 0 selects slave mode |
| cpol | input | 1 | Idle level of the serial clock |
| lsb_first | input | 1 | 1 sends bit 0 first, 0 sends bit 7 first |
| half_bit | input | HALF_W | System clocks per half bit (0 is treated as 1) |
| wr_valid | input | 1 | Loads `wr_data` into the write register |
| wr_data | input | DATA_W | Byte to send |
| rd_ack | input | 1 | Clears the completion flag |
| rd_done | output | 1 | Completion flag, sticky |
| rd_data | output | DATA_W | Last received byte |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_i | input | 1 | Select in, active low (slave) |
| ss_o | output | 1 | Select out, active low (master) |
| ss_oe | output | 1 | Select output enable |
| mosi_i | input | 1 | Master-to-slave data in (slave) |
| mosi_o | output | 1 | Master-to-slave data out (master) |
| mosi_oe | output | 1 | Master-to-slave output enable |
| miso_i | input | 1 | Slave-to-master data in (master) |
| miso_o | output | 1 | Slave-to-master data out (slave) |
| miso_oe | output | 1 | Slave-to-master output enable |

## Verification
The bench checks how the first slave bit is presented. A design that waited for a clock edge before loading would show the wrong `miso_o` level right after select falls. It aborts a slave byte partway through. A bit counter that is not cleared when select rises would raise the flag early or shift the next byte out of alignment. It also checks the distance from select falling to the first edge at divide ratio 2, and the select gap between back-to-back master bytes, where an off-by-one in the divider reload shows up. Both bit orders and both clock polarities are exercised, so a swapped shift direction or an inverted edge role corrupts the byte the bench compares.

// File: rtl/spi_pkg.sv
package spi_pkg;
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_TAIL = 2'd2,
        MS_GAP  = 2'd3
    } mst_state_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= d[g];
                stab_q <= meta_q;
            end
        end
        assign q[g] = stab_q;
    end
endmodule

// File: rtl/spi_halfbit_timer.sv
module spi_halfbit_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          tick
);
    logic [CW-1:0] cnt_d, cnt_q, reload;

    // a zero setting behaves as one clock per half bit
    assign reload = (half == '0) ? '0 : half - 1'b1;
    assign tick   = run && (cnt_q == '0);

    always_comb begin
        if (!run || cnt_q == '0) cnt_d = reload;
        else                     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample,
    input  logic         in_bit,
    input  logic         shift,
    input  logic         lsb_first,
    output logic         out_bit,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] sh_d, sh_q;
    logic         lat_d, lat_q;

    assign out_bit = lsb_first ? sh_q[0] : sh_q[W-1];
    // word as it stands once the bit being sampled now is shifted in
    assign rx_word = lsb_first ? {in_bit, sh_q[W-1:1]} : {sh_q[W-2:0], in_bit};

    always_comb begin
        sh_d  = sh_q;
        lat_d = lat_q;
        if (sample) lat_d = in_bit;
        if (load)
            sh_d = load_val;
        else if (shift)
            sh_d = lsb_first ? {lat_q, sh_q[W-1:1]} : {sh_q[W-2:0], lat_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            lat_q <= 1'b0;
        end else begin
            sh_q  <= sh_d;
            lat_q <= lat_d;
        end
    end
endmodule

// File: rtl/spi_cpha0_engine.sv
module spi_cpha0_engine
    import spi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic [HALF_W-1:0] half_bit,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_ack,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe
);
    localparam int BIT_W  = $clog2(DATA_W + 1);
    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam logic [EDGE_W-1:0] LAST_LEAD = EDGE_W'(2 * DATA_W - 2);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0]  ALL_BITS  = BIT_W'(DATA_W);

    typedef struct packed {
        mst_state_e        mst;
        logic [EDGE_W-1:0] edges;
        logic              phase;
        logic              ss_out;
        logic [DATA_W-1:0] tx_hold;
        logic              tx_full;
        logic [DATA_W-1:0] rx_byte;
        logic              done;
        logic              slv_act;
        logic [BIT_W-1:0]  bits;
        logic              sck_prev;
        logic              ss_prev;
        logic              oe_mst;
        logic              oe_slv;
    } state_t;

    state_t st_d, st_q;

    logic              sck_s, ss_s;
    logic              tick, tmr_run;
    logic              ld, smp, shf, done_set;
    logic              in_bit, out_bit;
    logic [DATA_W-1:0] rx_word;
    logic              ss_fall, ss_rise, lead, trail;

    spi_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_i, sck_i}),
        .q     ({ss_s, sck_s})
    );

    assign tmr_run = en && master && (st_q.mst != MS_IDLE);

    spi_halfbit_timer #(.CW(HALF_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .half  (half_bit),
        .tick  (tick)
    );

    assign in_bit = master ? miso_i : mosi_i;

    spi_shreg #(.W(DATA_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_val  (st_q.tx_hold),
        .sample    (smp),
        .in_bit    (in_bit),
        .shift     (shf),
        .lsb_first (lsb_first),
        .out_bit   (out_bit),
        .rx_word   (rx_word)
    );

    // slave-side edge events from the resynchronised pins
    assign ss_fall = st_q.ss_prev && !ss_s;
    assign ss_rise = !st_q.ss_prev && ss_s;
    assign lead    = st_q.slv_act && !ss_s && (st_q.sck_prev == cpol) &&
                     (sck_s != cpol) && (st_q.bits != ALL_BITS);
    assign trail   = st_q.slv_act && !ss_s && (st_q.sck_prev != cpol) &&
                     (sck_s == cpol);

    always_comb begin
        st_d     = st_q;
        ld       = 1'b0;
        smp      = 1'b0;
        shf      = 1'b0;
        done_set = 1'b0;
        st_d.sck_prev = sck_s;
        st_d.ss_prev  = ss_s;

        if (!en) begin
            st_d.mst     = MS_IDLE;
            st_d.edges   = '0;
            st_d.phase   = 1'b0;
            st_d.ss_out  = 1'b1;
            st_d.slv_act = 1'b0;
            st_d.bits    = '0;
        end else if (master) begin
            st_d.slv_act = 1'b0;
            st_d.bits    = '0;
            unique case (st_q.mst)
                MS_IDLE: begin
                    if (st_q.tx_full) begin
                        ld           = 1'b1;
                        st_d.tx_full = 1'b0;
                        st_d.ss_out  = 1'b0;
                        st_d.edges   = '0;
                        st_d.mst     = MS_RUN;
                    end
                end
                MS_RUN: begin
                    if (tick) begin
                        st_d.edges = st_q.edges + 1'b1;
                        if (!st_q.edges[0]) begin
                            st_d.phase = 1'b1;
                            smp        = 1'b1;
                            if (st_q.edges == LAST_LEAD) begin
                                st_d.rx_byte = rx_word;
                                done_set     = 1'b1;
                            end
                        end else begin
                            st_d.phase = 1'b0;
                            shf        = 1'b1;
                            if (st_q.edges == LAST_EDGE) st_d.mst = MS_TAIL;
                        end
                    end
                end
                MS_TAIL: begin
                    if (tick) begin
                        st_d.ss_out = 1'b1;
                        st_d.mst    = MS_GAP;
                    end
                end
                MS_GAP: begin
                    if (tick) st_d.mst = MS_IDLE;
                end
                default: st_d.mst = MS_IDLE;
            endcase
        end else begin
            st_d.mst    = MS_IDLE;
            st_d.edges  = '0;
            st_d.phase  = 1'b0;
            st_d.ss_out = 1'b1;
            if (ss_fall) begin
                ld           = 1'b1;
                st_d.tx_full = 1'b0;
                st_d.slv_act = 1'b1;
                st_d.bits    = '0;
            end else if (ss_rise) begin
                st_d.slv_act = 1'b0;
                st_d.bits    = '0;
            end else if (lead) begin
                smp       = 1'b1;
                st_d.bits = st_q.bits + 1'b1;
                if (st_q.bits == LAST_BIT) begin
                    st_d.rx_byte = rx_word;
                    done_set     = 1'b1;
                end
            end else if (trail) begin
                shf = 1'b1;
            end
        end

        if (wr_valid) begin
            st_d.tx_hold = wr_data;
            st_d.tx_full = 1'b1;
        end

        if (done_set)    st_d.done = 1'b1;
        else if (rd_ack) st_d.done = 1'b0;

        st_d.oe_mst = en && master;
        st_d.oe_slv = en && !master && st_d.slv_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.ss_out  <= 1'b1;
            st_q.ss_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o   = cpol ^ st_q.phase;
    assign ss_o    = st_q.ss_out;
    assign mosi_o  = out_bit;
    assign miso_o  = out_bit;
    assign sck_oe  = st_q.oe_mst;
    assign ss_oe   = st_q.oe_mst;
    assign mosi_oe = st_q.oe_mst;
    assign miso_oe = st_q.oe_slv;
    assign rd_done = st_q.done;
    assign rd_data = st_q.rx_byte;
endmodule

// File: rtl/spi_cpha0_checker.sv
module spi_cpha0_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic master,
    input logic cpol,
    input logic rd_ack,
    input logic rd_done,
    input logic sck_o,
    input logic sck_oe,
    input logic ss_o,
    input logic ss_oe,
    input logic mosi_oe,
    input logic miso_oe
);
    // R1: disabling releases every pin one clock later
    a_r1_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sck_oe && !ss_oe && !mosi_oe && !miso_oe));

    // R2: the clock leaves idle only while select is low
    a_r2_select_low_when_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && sck_oe && (sck_o != cpol)) |-> !ss_o);

    // R5: with select high the master clock rests at the polarity level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && ss_o) |-> (sck_o == cpol));

    // R10: completion flag holds until acknowledged
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_ack) |=> rd_done);

    // R11: master and slave drivers never enabled together
    a_r11_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_oe && miso_oe));
endmodule

bind spi_cpha0_engine spi_cpha0_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .master  (master),
    .cpol    (cpol),
    .rd_ack  (rd_ack),
    .rd_done (rd_done),
    .sck_o   (sck_o),
    .sck_oe  (sck_oe),
    .ss_o    (ss_o),
    .ss_oe   (ss_oe),
    .mosi_oe (mosi_oe),
    .miso_oe (miso_oe)
);

// File: tb/spi_cpha0_engine_tb_top.sv
module spi_cpha0_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HS         = 8;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n, en, master, cpol, lsb_first;
    logic [7:0] half_bit;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       rd_ack = 1'b0;
    logic       rd_done;
    logic [7:0] rd_data;
    logic       sck_i, sck_o, sck_oe, ss_i, ss_o, ss_oe;
    logic       mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    bit  auto_ack = 1'b1;
    int  ack_req = 0;
    int  ack_done = 0;

    spi_cpha0_engine dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .cpol(cpol),
        .lsb_first(lsb_first), .half_bit(half_bit), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_ack(rd_ack), .rd_done(rd_done), .rd_data(rd_data),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic bitof(logic [7:0] b, int i);
        return lsb_first ? b[i] : b[7-i];
    endfunction

    // scoreboard monitor: pops one expected byte per completion
    always @(negedge clk) begin
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (ack_req != ack_done) begin
            rd_ack = 1'b1;
            ack_done++;
        end else if (auto_ack && rd_done) begin
            if (exp_q.size() == 0) begin
                check_eq("R9", "completion with nothing expected", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check_eq("R3 R8", "rd_data", int'(rd_data), int'(e));
            end
            rd_ack = 1'b1;
        end
    end

    // behavioural slave answering the block in master mode
    logic [7:0] sb_tx = 8'h00;
    logic [7:0] sb_rx = 8'h00;
    int  sb_idx = 0, sb_leads = 0, first_delay = 0, last_gap = 0;
    bit  got_first = 1'b0, have_rise = 1'b0;
    time t_fall = 0, t_rise = 0;
    logic prev_ss = 1'b1, prev_sck = 1'b0;

    always @(ss_o, sck_o) begin
        if (master === 1'b1 && en === 1'b1) begin
            if (prev_ss === 1'b1 && ss_o === 1'b0) begin
                t_fall = $time;
                if (have_rise) last_gap = int'(($time - t_rise) / CLK_PERIOD);
                sb_idx = 0; sb_rx = 8'h00; sb_leads = 0; got_first = 1'b0;
                miso_i = bitof(sb_tx, 0);
            end else if (prev_ss === 1'b0 && ss_o === 1'b1) begin
                t_rise = $time;
                have_rise = 1'b1;
            end else if (ss_o === 1'b0 && sck_o !== prev_sck) begin
                if (!got_first) begin
                    first_delay = int'(($time - t_fall) / CLK_PERIOD);
                    got_first = 1'b1;
                end
                if (sck_o != cpol) begin
                    sb_rx = lsb_first ? {mosi_o, sb_rx[7:1]} : {sb_rx[6:0], mosi_o};
                    sb_leads++;
                end else begin
                    sb_idx++;
                    if (sb_idx < 8) miso_i = bitof(sb_tx, sb_idx);
                end
            end
        end
        prev_ss  = ss_o;
        prev_sck = sck_o;
    end

    task automatic write_byte(logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic m_xfer(logic [7:0] tx, logic [7:0] stx, bit push, string tag);
        int h;
        h = (half_bit == 0) ? 1 : int'(half_bit);
        sb_tx = stx;
        if (push) exp_q.push_back(stx);
        write_byte(tx);
        @(posedge ss_o);
        @(negedge clk);
        check_eq(tag, "byte seen by slave", int'(sb_rx), int'(tx));
        check_eq("R3", "leading edges per byte", sb_leads, 8);
        check_eq("R2", "select to first edge", first_delay, h);
        repeat (4) @(negedge clk);
    endtask

    task automatic s_xfer(logic [7:0] mtx, logic [7:0] stx, int nbits, bit push, string tag);
        logic [7:0] got;
        got = 8'h00;
        @(negedge clk);
        sck_i = cpol; mosi_i = bitof(mtx, 0); ss_i = 1'b0;
        if (push) exp_q.push_back(mtx);
        repeat (5) @(negedge clk);
        check_eq("R7", "miso_oe after select", int'(miso_oe), 1);
        check_eq("R7", "first bit before clock", int'(miso_o), int'(bitof(stx, 0)));
        for (int i = 0; i < nbits; i++) begin
            repeat (HS) @(negedge clk);
            got = lsb_first ? {miso_o, got[7:1]} : {got[6:0], miso_o};
            sck_i = ~cpol;
            repeat (HS) @(negedge clk);
            sck_i = cpol;
            if (i < 7) mosi_i = bitof(mtx, i + 1);
        end
        repeat (HS) @(negedge clk);
        ss_i = 1'b1;
        repeat (HS) @(negedge clk);
        if (nbits == 8) begin
            check_eq(tag, "bits seen on miso", int'(got), int'(stx));
            check_eq("R8", "scoreboard drained", exp_q.size(), 0);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=%0d expected=0", WD_CYCLES);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; master = 1'b1; cpol = 1'b0; lsb_first = 1'b0;
        half_bit = 8'd3; wr_valid = 1'b0; wr_data = 8'h00;
        sck_i = 1'b0; ss_i = 1'b1; mosi_i = 1'b0; miso_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check_eq("R1", "sck_oe after reset", int'(sck_oe), 0);
        check_eq("R1", "ss_oe after reset", int'(ss_oe), 0);
        check_eq("R1", "mosi_oe after reset", int'(mosi_oe), 0);
        check_eq("R1", "miso_oe after reset", int'(miso_oe), 0);
        check_eq("R1", "rd_done after reset", int'(rd_done), 0);
        check_eq("R1", "ss_o after reset", int'(ss_o), 1);

        // master mode
        en = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R11", "sck_oe in master", int'(sck_oe), 1);
        check_eq("R11", "miso_oe in master", int'(miso_oe), 0);
        check_eq("R5", "idle clock cpol=0", int'(sck_o), 0);
        m_xfer(8'hA5, 8'h3C, 1'b1, "R3 msb");
        lsb_first = 1'b1;
        m_xfer(8'h1E, 8'hC7, 1'b1, "R4 lsb master");
        lsb_first = 1'b0; cpol = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R5", "idle clock cpol=1", int'(sck_o), 1);
        m_xfer(8'h6B, 8'h94, 1'b1, "R5 cpol1");
        half_bit = 8'd0;
        m_xfer(8'hF0, 8'h0E, 1'b1, "R2 ratio two");

        // R6 back-to-back bytes
        cpol = 1'b0; half_bit = 8'd2;
        repeat (2) @(negedge clk);
        sb_tx = 8'h55;
        exp_q.push_back(8'h55); exp_q.push_back(8'h55);
        write_byte(8'hD2);
        write_byte(8'h2D);
        @(posedge ss_o);
        @(negedge ss_o);
        @(negedge clk);
        checks++;
        if (last_gap < 2) begin
            errors++;
            $display("FAIL R6 select gap actual=%0d expected>=%0d", last_gap, 2);
        end
        @(posedge ss_o);
        @(negedge clk);
        check_eq("R6", "second byte", int'(sb_rx), 8'h2D);
        repeat (6) @(negedge clk);
        check_eq("R6", "scoreboard drained", exp_q.size(), 0);

        // R10 sticky flag
        auto_ack = 1'b0;
        m_xfer(8'h99, 8'h42, 1'b0, "R3 no ack");
        repeat (20) @(negedge clk);
        check_eq("R10", "flag held without ack", int'(rd_done), 1);
        check_eq("R10", "rd_data held", int'(rd_data), 8'h42);
        ack_req++;
        repeat (3) @(negedge clk);
        check_eq("R10", "flag cleared by ack", int'(rd_done), 0);
        auto_ack = 1'b1;

        // R1 disable releases pins
        en = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1", "sck_oe when disabled", int'(sck_oe), 0);
        check_eq("R1", "ss_oe when disabled", int'(ss_oe), 0);
        check_eq("R1", "mosi_oe when disabled", int'(mosi_oe), 0);

        // slave mode
        master = 1'b0; en = 1'b1; cpol = 1'b0; lsb_first = 1'b0; sck_i = 1'b0;
        write_byte(8'hC3);
        repeat (3) @(negedge clk);
        check_eq("R11", "sck_oe in slave", int'(sck_oe), 0);
        check_eq("R11", "ss_oe in slave", int'(ss_oe), 0);
        check_eq("R11", "mosi_oe in slave", int'(mosi_oe), 0);
        check_eq("R11", "miso_oe unselected", int'(miso_oe), 0);
        s_xfer(8'h5A, 8'hC3, 8, 1'b1, "R8 slave msb");
        s_xfer(8'h12, 8'hC3, 8, 1'b1, "R12 resend");

        // R9 abort then a clean byte
        write_byte(8'h3E);
        s_xfer(8'hFF, 8'h3E, 3, 1'b0, "R9 partial");
        check_eq("R9", "no flag after abort", int'(rd_done), 0);
        check_eq("R9", "miso_oe after abort", int'(miso_oe), 0);
        s_xfer(8'h77, 8'h3E, 8, 1'b1, "R9 restart");

        // R4 and R5 in slave mode
        lsb_first = 1'b1; cpol = 1'b1; sck_i = 1'b1;
        repeat (4) @(negedge clk);
        s_xfer(8'hB2, 8'h3E, 8, 1'b1, "R4 lsb slave cpol1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule